// File: doc/BRIEF.md
# Super I/O configuration port controller

This block is the configuration register unit of a multi-function peripheral I/O chip on an 8-bit ISA-style I/O bus. It answers at two addresses. The lower address is the configuration and index port, and a strap input places it at one of two locations. The data port sits one address above it. After reset the block is in run state. In that state the register file is closed, and the only thing the lower port does is watch for a two-byte unlock key.

Once the block is unlocked, host software writes a register number to the index port and reads or writes that register through the data port. Global registers hold a chip identity, a revision, a power-enable byte and a logical device number. The logical device number selects one of nine per-device register banks, and the rest of the index space maps onto that bank. Each bank drives the activate flag, 16-bit base address and interrupt selection of one peripheral function. The keyboard bank adds a second interrupt select. The floppy and parallel banks add a DMA channel select, and the floppy bank also has a mode byte and an option byte. A closing key byte returns the block to run state.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: With `strap_alt` low, the configuration/index port is 0x3F0 and the data port is 0x3F1. With `strap_alt` high, they are 0x370 and 0x371. Accesses to the address pair that is not selected are not decoded.
- R2: After reset the block is in run state (`cfg_mode` low), the index register is 0, and all device outputs are 0: `dev_active`, `dev_base`, `dev_irq`, `dev_dma`, `kbd_irq2`, `pwr_en`, `fdd_mode` and `fdd_opt`.
- R3: Two consecutive writes of 0x55 to the configuration port put the block in config state. `cfg_mode` goes high at the clock edge that takes the second write.
- R4: A write of any byte other than 0x55 to the configuration port, made while the unlock key is incomplete, clears the key progress. A new pair of 0x55 writes is then needed.
- R5: In config state, a write of 0xAA to the configuration port returns the block to run state and does not load the index.
- R6: In run state, reads of either port return 0xFF, and data-port writes change no register and no output.
- R7: In config state, any other byte written to the configuration port loads the index register, and a read of that port returns the index.
- R8: The global registers are: index 0x07, the logical device number (4 bits, read/write, upper bits read 0); index 0x20, which reads 0x02; index 0x21, which reads the `REV_ID` parameter (default 0x01); and index 0x22, the power byte, whose bits 5..0 drive `pwr_en` and whose bits 7..6 read 0.
- R9: For a selected device 0 to 8, the bank registers are: index 0x30, the activate flag (bit 0 drives `dev_active[ldn]`, other bits read 0); index 0x60, the high byte of `dev_base[ldn*16+:16]`; index 0x61, the low byte; and index 0x70, `dev_irq[ldn*8+:8]`.
- R10: Index 0x72 exists only for device 7 and drives `kbd_irq2`. Index 0x74 exists only for devices 0 and 3 and drives `dev_dma[ldn*8+:8]`. For any other device these read 0x00 and ignore writes.
- R11: Device 0 has two 8-bit read/write registers: index 0x90 drives `fdd_mode` and index 0x91 drives `fdd_opt`. A read-modify-write preserves the bits it does not change.
- R12: Any index not listed above, and any bank index while the logical device number is 9 or more, reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_alt | input | 1 | Base select: 0 gives 0x3F0, 1 gives 0x370 |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address |
| cfg_mode | output | 1 | High in config state |
| dev_active | output | 9 | Activate flag per device |
| dev_base | output | 144 | 16-bit base address per device |
| dev_irq | output | 72 | Primary interrupt select per device |
| dev_dma | output | 72 | DMA channel per device (0 where absent) |
| kbd_irq2 | output | 8 | Second interrupt select of the keyboard device |
| pwr_en | output | 6 | Power enable bits for devices 0 to 5 |
| fdd_mode | output | 8 | Floppy mode byte |
| fdd_opt | output | 8 | Floppy option byte |

## Verification
The bench breaks the unlock key with a foreign byte between two 0x55 writes. A detector that only counts 0x55 bytes would unlock early at that point. It writes the keyboard-only and DMA-only registers on devices that lack them. A bank without per-device gating would then read back a non-zero value or drive `dev_dma` from the wrong device. It selects a device number above 8 and an unused index, where a decoder that wraps or aliases would change `dev_active`. It writes to the data port after the closing key and repeats the unlock at the address pair that is not strapped; a leaky run state would change outputs or unlock.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    localparam int DW     = 8;
    localparam int AW     = 16;
    localparam int N_DEV  = 9;
    localparam int LDN_W  = 4;
    localparam int PWR_W  = 6;

    localparam logic [AW-1:0] BASE_PRI = 16'h03F0;
    localparam logic [AW-1:0] BASE_ALT = 16'h0370;

    localparam logic [DW-1:0] KEY_OPEN  = 8'h55;
    localparam logic [DW-1:0] KEY_CLOSE = 8'hAA;
    localparam logic [DW-1:0] CHIP_ID   = 8'h02;

    // register numbers decoded by host software
    localparam logic [DW-1:0] IX_LDN   = 8'h07;
    localparam logic [DW-1:0] IX_ID    = 8'h20;
    localparam logic [DW-1:0] IX_REV   = 8'h21;
    localparam logic [DW-1:0] IX_PWR   = 8'h22;
    localparam logic [DW-1:0] IX_ACT   = 8'h30;
    localparam logic [DW-1:0] IX_BHI   = 8'h60;
    localparam logic [DW-1:0] IX_BLO   = 8'h61;
    localparam logic [DW-1:0] IX_IRQ   = 8'h70;
    localparam logic [DW-1:0] IX_IRQ2  = 8'h72;
    localparam logic [DW-1:0] IX_DMA   = 8'h74;
    localparam logic [DW-1:0] IX_FMODE = 8'h90;
    localparam logic [DW-1:0] IX_FOPT  = 8'h91;

    localparam int LDN_FDC = 0;
    localparam int LDN_PAR = 3;
    localparam int LDN_KBD = 7;

    localparam logic [N_DEV-1:0] IRQ2_MASK = N_DEV'(1) << LDN_KBD;
    localparam logic [N_DEV-1:0] DMA_MASK  = (N_DEV'(1) << LDN_FDC) | (N_DEV'(1) << LDN_PAR);

    typedef enum logic [1:0] {KS_RUN, KS_ARMED, KS_CFG} key_st_e;

    typedef struct packed {
        key_st_e st;
    } key_t;

    typedef struct packed {
        logic [DW-1:0]              idx;
        logic [LDN_W-1:0]           ldn;
        logic [PWR_W-1:0]           pwr;
        logic [N_DEV-1:0]           act;
        logic [N_DEV-1:0][DW-1:0]   bhi;
        logic [N_DEV-1:0][DW-1:0]   blo;
        logic [N_DEV-1:0][DW-1:0]   irq;
        logic [N_DEV-1:0][DW-1:0]   irq2;
        logic [N_DEV-1:0][DW-1:0]   dma;
        logic [DW-1:0]              fmode;
        logic [DW-1:0]              fopt;
    } bank_t;
endpackage

// File: rtl/sio_port_dec.sv
module sio_port_dec
    import sio_cfg_pkg::*;
(
    input  logic          strap_alt,
    input  logic [AW-1:0] io_addr,
    output logic          hit_idx,
    output logic          hit_dat
);
    logic [AW-1:0] base;

    always_comb begin
        base    = strap_alt ? BASE_ALT : BASE_PRI;
        hit_idx = (io_addr == base);
        hit_dat = (io_addr == base + AW'(1));
    end
endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_idx,
    input  logic [DW-1:0] wdata,
    output logic          cfg_mode,
    output logic          idx_we
);
    key_t k_d, k_q;

    always_comb begin
        k_d    = k_q;
        idx_we = 1'b0;
        if (wr_idx) begin
            unique case (k_q.st)
                KS_RUN:   k_d.st = (wdata == KEY_OPEN) ? KS_ARMED : KS_RUN;
                KS_ARMED: k_d.st = (wdata == KEY_OPEN) ? KS_CFG : KS_RUN;
                KS_CFG: begin
                    if (wdata == KEY_CLOSE) k_d.st = KS_RUN;
                    else                    idx_we = 1'b1;
                end
                default:  k_d.st = KS_RUN;
            endcase
        end
        cfg_mode = (k_q.st == KS_CFG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '{st: KS_RUN};
        else        k_q <= k_d;
    end
endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
    import sio_cfg_pkg::*;
#(
    parameter logic [DW-1:0] REV_ID = 8'h01
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    idx_we,
    input  logic                    dat_we,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           cur_idx,
    output logic [DW-1:0]           dat_rd,
    output logic [N_DEV-1:0]        dev_active,
    output logic [N_DEV*2*DW-1:0]   dev_base,
    output logic [N_DEV*DW-1:0]     dev_irq,
    output logic [N_DEV*DW-1:0]     dev_dma,
    output logic [DW-1:0]           kbd_irq2,
    output logic [PWR_W-1:0]        pwr_en,
    output logic [DW-1:0]           fdd_mode,
    output logic [DW-1:0]           fdd_opt
);
    bank_t s_d, s_q;

    logic             sel_ok;
    logic [LDN_W-1:0] ldn_i;
    logic             has_irq2, has_dma, is_fdc;

    always_comb begin
        s_d      = s_q;
        sel_ok   = (s_q.ldn < LDN_W'(N_DEV));
        ldn_i    = sel_ok ? s_q.ldn : '0;
        has_irq2 = sel_ok && IRQ2_MASK[ldn_i];
        has_dma  = sel_ok && DMA_MASK[ldn_i];
        is_fdc   = sel_ok && (ldn_i == LDN_W'(LDN_FDC));

        // read mux for the data port
        dat_rd = '0;
        unique case (s_q.idx)
            IX_LDN:   dat_rd = DW'(s_q.ldn);
            IX_ID:    dat_rd = CHIP_ID;
            IX_REV:   dat_rd = REV_ID;
            IX_PWR:   dat_rd = DW'(s_q.pwr);
            IX_ACT:   if (sel_ok)   dat_rd = DW'(s_q.act[ldn_i]);
            IX_BHI:   if (sel_ok)   dat_rd = s_q.bhi[ldn_i];
            IX_BLO:   if (sel_ok)   dat_rd = s_q.blo[ldn_i];
            IX_IRQ:   if (sel_ok)   dat_rd = s_q.irq[ldn_i];
            IX_IRQ2:  if (has_irq2) dat_rd = s_q.irq2[ldn_i];
            IX_DMA:   if (has_dma)  dat_rd = s_q.dma[ldn_i];
            IX_FMODE: if (is_fdc)   dat_rd = s_q.fmode;
            IX_FOPT:  if (is_fdc)   dat_rd = s_q.fopt;
            default:  dat_rd = '0;
        endcase

        if (idx_we) s_d.idx = wdata;

        if (dat_we) begin
            unique case (s_q.idx)
                IX_LDN:   s_d.ldn = wdata[LDN_W-1:0];
                IX_PWR:   s_d.pwr = wdata[PWR_W-1:0];
                IX_ACT:   if (sel_ok)   s_d.act[ldn_i]  = wdata[0];
                IX_BHI:   if (sel_ok)   s_d.bhi[ldn_i]  = wdata;
                IX_BLO:   if (sel_ok)   s_d.blo[ldn_i]  = wdata;
                IX_IRQ:   if (sel_ok)   s_d.irq[ldn_i]  = wdata;
                IX_IRQ2:  if (has_irq2) s_d.irq2[ldn_i] = wdata;
                IX_DMA:   if (has_dma)  s_d.dma[ldn_i]  = wdata;
                IX_FMODE: if (is_fdc)   s_d.fmode = wdata;
                IX_FOPT:  if (is_fdc)   s_d.fopt  = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_idx    = s_q.idx;
    assign dev_active = s_q.act;
    assign kbd_irq2   = s_q.irq2[LDN_KBD];
    assign pwr_en     = s_q.pwr;
    assign fdd_mode   = s_q.fmode;
    assign fdd_opt    = s_q.fopt;

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        assign dev_base[g*2*DW +: 2*DW] = {s_q.bhi[g], s_q.blo[g]};
        assign dev_irq[g*DW +: DW]      = s_q.irq[g];
        if (DMA_MASK[g]) begin : g_dma
            assign dev_dma[g*DW +: DW] = s_q.dma[g];
        end else begin : g_nodma
            assign dev_dma[g*DW +: DW] = '0;
        end
    end
endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h01
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strap_alt,
    input  logic [AW-1:0]           io_addr,
    input  logic                    io_wr,
    input  logic                    io_rd,
    input  logic [DW-1:0]           io_wdata,
    output logic [DW-1:0]           io_rdata,
    output logic                    cfg_mode,
    output logic [N_DEV-1:0]        dev_active,
    output logic [N_DEV*2*DW-1:0]   dev_base,
    output logic [N_DEV*DW-1:0]     dev_irq,
    output logic [N_DEV*DW-1:0]     dev_dma,
    output logic [DW-1:0]           kbd_irq2,
    output logic [PWR_W-1:0]        pwr_en,
    output logic [DW-1:0]           fdd_mode,
    output logic [DW-1:0]           fdd_opt
);
    logic          hit_idx, hit_dat;
    logic          idx_we, dat_we;
    logic [DW-1:0] cur_idx, dat_rd;

    sio_port_dec u_dec (
        .strap_alt (strap_alt),
        .io_addr   (io_addr),
        .hit_idx   (hit_idx),
        .hit_dat   (hit_dat)
    );

    sio_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_idx   (io_wr && hit_idx),
        .wdata    (io_wdata),
        .cfg_mode (cfg_mode),
        .idx_we   (idx_we)
    );

    assign dat_we = cfg_mode && io_wr && hit_dat;

    sio_reg_bank #(.REV_ID(REV_ID)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_we     (idx_we),
        .dat_we     (dat_we),
        .wdata      (io_wdata),
        .cur_idx    (cur_idx),
        .dat_rd     (dat_rd),
        .dev_active (dev_active),
        .dev_base   (dev_base),
        .dev_irq    (dev_irq),
        .dev_dma    (dev_dma),
        .kbd_irq2   (kbd_irq2),
        .pwr_en     (pwr_en),
        .fdd_mode   (fdd_mode),
        .fdd_opt    (fdd_opt)
    );

    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && cfg_mode) begin
            if (hit_idx)      io_rdata = cur_idx;
            else if (hit_dat) io_rdata = dat_rd;
        end
    end
endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk
    import sio_cfg_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    strap_alt,
    input logic [AW-1:0]           io_addr,
    input logic                    io_wr,
    input logic                    io_rd,
    input logic [DW-1:0]           io_wdata,
    input logic [DW-1:0]           io_rdata,
    input logic                    cfg_mode,
    input logic [DW-1:0]           cur_idx,
    input logic [N_DEV-1:0]        dev_active,
    input logic [N_DEV*2*DW-1:0]   dev_base,
    input logic [N_DEV*DW-1:0]     dev_irq,
    input logic [N_DEV*DW-1:0]     dev_dma,
    input logic [DW-1:0]           kbd_irq2,
    input logic [PWR_W-1:0]        pwr_en
);
    logic [AW-1:0] c_lo, c_hi;
    assign c_lo = strap_alt ? 16'h0370 : 16'h03F0;
    assign c_hi = c_lo + 16'd1;

    AST_RUN_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_rd && (io_addr == c_lo || io_addr == c_hi)) |-> io_rdata == 8'hFF); // R6

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> ($stable(dev_active) && $stable(dev_base) && $stable(dev_irq)
                       && $stable(dev_dma) && $stable(kbd_irq2) && $stable(pwr_en))); // R6

    AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> $past(io_wr && io_addr == c_lo && io_wdata == 8'h55)); // R3

    AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_wr && io_addr == c_lo && io_wdata == 8'hAA) |=> !cfg_mode); // R5

    AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_rd && io_addr == c_hi && cur_idx == 8'h20) |-> io_rdata == 8'h02); // R8
endmodule

bind sio_cfg_ctrl sio_cfg_chk u_chk (.*);

// File: tb/tb_sio_cfg_ctrl.sv
module tb_sio_cfg_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strap_alt = 1'b0;
    logic [15:0]  io_addr = '0;
    logic         io_wr = 1'b0;
    logic         io_rd = 1'b0;
    logic [7:0]   io_wdata = '0;
    logic [7:0]   io_rdata;
    logic         cfg_mode;
    logic [8:0]   dev_active;
    logic [143:0] dev_base;
    logic [71:0]  dev_irq;
    logic [71:0]  dev_dma;
    logic [7:0]   kbd_irq2;
    logic [5:0]   pwr_en;
    logic [7:0]   fdd_mode;
    logic [7:0]   fdd_opt;

    sio_cfg_ctrl dut (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(logic [143:0] act, logic [143:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [7:0] exp, string tag);
        rd_item_t it;
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    // monitor: pops expected read data when a read is on the bus
    initial forever begin
        @(posedge clk);
        #1;
        if (io_rd) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty actual=%0h expected=none", io_rdata);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                if (io_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%0h expected=%0h", it.tag, io_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    localparam logic [15:0] P = 16'h03F0;
    localparam logic [15:0] D = 16'h03F1;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk(144'(cfg_mode), 0, "R2 cfg_mode");
        chk(144'(dev_active), 0, "R2 dev_active");
        chk(dev_base, 0, "R2 dev_base");
        chk(144'(dev_irq), 0, "R2 dev_irq");
        chk(144'(dev_dma), 0, "R2 dev_dma");
        chk(144'({kbd_irq2, pwr_en, fdd_mode, fdd_opt}), 0, "R2 misc");
        rd(P, 8'hFF, "R6 run read index");
        rd(D, 8'hFF, "R6 run read data");
        wr(D, 8'h01);
        chk(144'(dev_active), 0, "R6 run write ignored");

        // R4 broken key, R3 unlock
        wr(P, 8'h55); wr(P, 8'h12); wr(P, 8'h55);
        chk(144'(cfg_mode), 0, "R4 broken key");
        wr(P, 8'h55);
        chk(144'(cfg_mode), 1, "R3 unlock");
        rd(P, 8'h00, "R2 index reset");

        // R7, R8 globals
        wr(P, 8'h20);
        rd(P, 8'h20, "R7 index readback");
        rd(D, 8'h02, "R8 chip id");
        wr(P, 8'h21);
        rd(D, 8'h01, "R8 revision");
        wr(P, 8'h22); wr(D, 8'hFF);
        rd(D, 8'h3F, "R8 power byte");
        chk(144'(pwr_en), 144'h3F, "R8 pwr_en");
        wr(P, 8'h07); wr(D, 8'h04);
        rd(D, 8'h04, "R8 ldn readback");

        // R9 serial bank, device 4
        wr(P, 8'h60); wr(D, 8'h03);
        wr(P, 8'h61); wr(D, 8'hF8);
        wr(P, 8'h70); wr(D, 8'h04);
        wr(P, 8'h30); wr(D, 8'hFF);
        rd(D, 8'h01, "R9 activate bit only");
        chk(144'(dev_active), 144'h010, "R9 dev_active");
        chk(144'(dev_base[4*16 +: 16]), 144'h03F8, "R9 dev_base");
        chk(144'(dev_irq[4*8 +: 8]), 144'h04, "R9 dev_irq");

        // R10 device-only registers on the wrong device
        wr(P, 8'h72); wr(D, 8'h0C);
        rd(D, 8'h00, "R10 irq2 absent");
        wr(P, 8'h74); wr(D, 8'h02);
        rd(D, 8'h00, "R10 dma absent");
        chk(144'({dev_dma, kbd_irq2}), 0, "R10 no stray dma/irq2");
        wr(P, 8'h07); wr(D, 8'h07);
        wr(P, 8'h72); wr(D, 8'h0C);
        rd(D, 8'h0C, "R10 kbd irq2 read");
        chk(144'(kbd_irq2), 144'h0C, "R10 kbd_irq2");
        wr(P, 8'h07); wr(D, 8'h03);
        wr(P, 8'h74); wr(D, 8'h03);
        chk(144'(dev_dma), 144'(72'h03) << 24, "R10 parallel dma");

        // R11 floppy mode/option with read-modify-write
        wr(P, 8'h90); wr(D, 8'h41);
        rd(D, 8'h00, "R11 mode absent on device 3");
        wr(P, 8'h07); wr(D, 8'h00);
        wr(P, 8'h90); wr(D, 8'h41);
        rd(D, 8'h41, "R11 mode read");
        wr(D, 8'h41 | 8'h0E);
        rd(D, 8'h4F, "R11 mode rmw");
        chk(144'(fdd_mode), 144'h4F, "R11 fdd_mode");
        wr(P, 8'h91); wr(D, 8'h5A);
        chk(144'(fdd_opt), 144'h5A, "R11 fdd_opt");

        // R12 out-of-range device and unused index
        wr(P, 8'h07); wr(D, 8'h0B);
        wr(P, 8'h30); wr(D, 8'h01);
        rd(D, 8'h00, "R12 ldn 11 reads 0");
        chk(144'(dev_active), 144'h010, "R12 ldn 11 write ignored");
        wr(P, 8'h2A); wr(D, 8'h77);
        rd(D, 8'h00, "R12 unused index");

        // R5 close key, then run-state writes ignored
        wr(P, 8'hAA);
        chk(144'(cfg_mode), 0, "R5 close key");
        rd(P, 8'hFF, "R6 run after close");
        wr(D, 8'h00);
        chk(144'(dev_active), 144'h010, "R6 data write after close");

        // R1 alternate base
        @(negedge clk);
        rst_n = 1'b0; strap_alt = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        wr(16'h03F0, 8'h55); wr(16'h03F0, 8'h55);
        chk(144'(cfg_mode), 0, "R1 old base ignored");
        wr(16'h0370, 8'h55); wr(16'h0370, 8'h55);
        chk(144'(cfg_mode), 1, "R1 alt base unlock");
        wr(16'h0370, 8'h20);
        rd(16'h0371, 8'h02, "R1 alt data port");

        repeat (2) @(negedge clk);
        chk(144'(sb.size()), 0, "R6 scoreboard drained");
        finish_run();
    end
endmodule